// File: doc/BRIEF.md
# ADC Trigger and Tracking Sequencer

This block sequences a successive-approximation converter that sits outside it. Software programs an 8-bit control word that enables the converter, picks how tracking behaves, and selects which event starts a conversion: a software write, one of four timer overflow pulses, or the rising edge of an asynchronous convert-start pin. On a start event the block drives a track request and then a convert request to the SAR core, and holds the convert request until the core reports done.

A free-running divider produces a one-cycle SAR clock strobe, which is passed to the core and also times the fixed three-strobe track window of the low-power track mode. When the busy state ends normally, a sticky completion flag is set. A separate sticky window flag is set from an external match input. Clearing the enable bit in the middle of a conversion abandons it.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control word reads 0x00. Read and write layout, bit 7 down to bit 0: enable, low-power track, completion flag, busy, window flag, then a 3-bit start source in bits 2:0.
- R2: While enable is 0, track_req and conv_req stay 0 and no trigger starts a conversion.
- R3: Start source codes: 000 software, 001 tmr_ovf[0], 010 tmr_ovf[2], 011 tmr_ovf[1], 100 rising edge of cnv_pin, 101 tmr_ovf[3]. Codes 110 and 111 start nothing, and pulses from unselected sources start nothing.
- R4: A write with busy (bit 4) set to 1 starts a conversion only when the written source field is 000 and enable is already 1. A write with busy 0 starts nothing.
- R5: Busy reads 1 from the start event until the SAR core's done pulse, and 0 otherwise. The completion flag (bit 5) is set when busy ends this way, and it stays set until a write clears it.
- R6: With low-power track 0 and enable 1, track_req is high whenever the block is idle and low while busy. track_req and conv_req are never high together.
- R7: With low-power track 1 and a source other than the pin, track_req stays low until a trigger arrives. The trigger then raises track_req for exactly 3 sar_tick strobes, and conv_req follows on the next cycle.
- R8: cnv_pin passes through a two-flop synchronizer. With low-power track 1 and source 100, track_req follows the synchronized pin being low, and the synchronized rising edge starts the conversion.
- R9: A one-cycle win_match pulse sets the window flag (bit 3), which stays set until a write clears it.
- R10: Writing enable to 0 during a conversion drops conv_req at once and busy within one cycle, and the completion flag is not set.
- R11: A hardware set of the completion flag or the window flag wins over a write that clears that flag in the same cycle.
- R12: A trigger that arrives while busy is ignored, so no second conversion follows.
- R13: sar_tick is a one-cycle strobe that repeats every sar_div+1 clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 8 | Control word write data |
| reg_rdata | output | 8 | Control word read data, including live busy |
| tmr_ovf | input | 4 | Timer overflow pulses, index 0 to 3 |
| cnv_pin | input | 1 | Asynchronous external convert-start pin |
| sar_div | input | 8 | SAR clock divider: strobe period is sar_div+1 |
| sar_done | input | 1 | One-cycle done pulse from the SAR core |
| win_match | input | 1 | One-cycle window-compare match from outside logic |
| sar_tick | output | 1 | SAR clock enable strobe |
| track_req | output | 1 | Track request to the SAR core |
| conv_req | output | 1 | Convert request to the SAR core, held until done |

## Verification
The assertions assume that sar_done arrives only while conv_req is high, and that it and the timer and match inputs are single-cycle pulses that are synchronous to clk. Only cnv_pin is taken to be asynchronous. The bench's SAR model follows these rules: it counts cycles of conv_req, answers with a one-cycle done, and restarts its count when conv_req drops. All timer and match pulses are driven for exactly one cycle on the falling clock edge, and sar_div is held constant while the strobe period is measured.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int N_TMR = 4;

    typedef enum logic [2:0] {
        SRC_SW   = 3'b000,
        SRC_T0   = 3'b001,
        SRC_T2   = 3'b010,
        SRC_T1   = 3'b011,
        SRC_PIN  = 3'b100,
        SRC_T3   = 3'b101,
        SRC_RSV6 = 3'b110,
        SRC_RSV7 = 3'b111
    } start_src_e;

    typedef struct packed {
        logic       en;
        logic       lp_track;
        logic       done_flag;
        logic       busy;
        logic       win_flag;
        start_src_e src;
    } ctl_word_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TRACK = 2'd1,
        ST_CONV  = 2'd2
    } seq_state_e;

    function automatic logic src_is_timer(start_src_e s);
        return (s == SRC_T0) || (s == SRC_T1) || (s == SRC_T2) || (s == SRC_T3);
    endfunction

    function automatic logic [1:0] timer_sel(start_src_e s);
        case (s)
            SRC_T0:  return 2'd0;
            SRC_T1:  return 2'd1;
            SRC_T2:  return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/adc_sar_tick.sv
module adc_sar_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = (cnt_q >= div);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    // R13
    tick_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && div != '0) |=> (!tick || div == '0));

endmodule

// File: rtl/adc_start_sel.sv
module adc_start_sel
    import adc_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  start_src_e       src,
    input  logic             sw_go,
    input  logic [N_TMR-1:0] tmr_ovf,
    input  logic             pin_async,
    output logic             pin_lvl,
    output logic             trig
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_prev_q;
    logic                   pin_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q     <= '0;
            pin_prev_q <= 1'b0;
        end else begin
            sync_q     <= {sync_q[SYNC_STAGES-2:0], pin_async};
            pin_prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign pin_lvl  = sync_q[SYNC_STAGES-1];
    assign pin_rise = pin_lvl && !pin_prev_q;

    always_comb begin
        trig = 1'b0;
        if (src == SRC_SW)           trig = sw_go;
        else if (src == SRC_PIN)     trig = en && pin_rise;
        else if (src_is_timer(src))  trig = en && tmr_ovf[timer_sel(src)];
    end

    // R3
    reserved_src_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_RSV6 || src == SRC_RSV7) |-> !trig);

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int TRACK_TICKS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic lp_track,
    input  logic pin_mode,
    input  logic pin_lvl,
    input  logic trig,
    input  logic sar_tick,
    input  logic sar_done,
    output logic busy,
    output logic done_pulse,
    output logic track_req,
    output logic conv_req
);
    localparam int CW = $clog2(TRACK_TICKS + 1);

    seq_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic          lp_timed;
    logic          idle_track;

    assign lp_timed = lp_track && !pin_mode;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (trig) begin
                    cnt_q   <= '0;
                    state_q <= lp_timed ? ST_TRACK : ST_CONV;
                end
                ST_TRACK: if (sar_tick) begin
                    if (cnt_q == CW'(TRACK_TICKS - 1)) state_q <= ST_CONV;
                    else                               cnt_q   <= cnt_q + 1'b1;
                end
                ST_CONV: if (sar_done) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        if (!lp_track)     idle_track = 1'b1;
        else if (pin_mode) idle_track = !pin_lvl;
        else               idle_track = 1'b0;
    end

    assign busy       = (state_q != ST_IDLE);
    assign done_pulse = en && (state_q == ST_CONV) && sar_done;
    assign track_req  = en && ((state_q == ST_TRACK) || (state_q == ST_IDLE && idle_track));
    assign conv_req   = en && (state_q == ST_CONV);

    // R6
    track_conv_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(track_req && conv_req));

    // R7
    track_leaves_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TRACK && !sar_tick) |=> (state_q != ST_CONV));

    // R10
    abort_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (state_q == ST_IDLE));

    // R12
    conv_holds_until_done_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CONV && en && !sar_done) |=> (state_q == ST_CONV));

endmodule

// File: rtl/adc_ctl_regs.sv
module adc_ctl_regs
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [7:0] wdata,
    input  logic       busy,
    input  logic       done_pulse,
    input  logic       win_match,
    output logic [7:0] rdata,
    output logic       en,
    output logic       lp_track,
    output start_src_e src,
    output logic       sw_go
);
    ctl_word_t wr_w;
    logic      done_q;
    logic      win_q;

    assign wr_w = ctl_word_t'(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            en       <= 1'b0;
            lp_track <= 1'b0;
            src      <= SRC_SW;
            done_q   <= 1'b0;
            win_q    <= 1'b0;
        end else begin
            if (wr) begin
                en       <= wr_w.en;
                lp_track <= wr_w.lp_track;
                src      <= wr_w.src;
            end
            if (done_pulse) done_q <= 1'b1;
            else if (wr)    done_q <= wr_w.done_flag;
            if (win_match)  win_q  <= 1'b1;
            else if (wr)    win_q  <= wr_w.win_flag;
        end
    end

    assign sw_go = wr && wr_w.busy && wr_w.en && en && (wr_w.src == SRC_SW);
    assign rdata = {en, lp_track, done_q, busy, win_q, src};

    // R5 R11
    done_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> done_q);

    // R9 R11
    win_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        win_match |=> win_q);

    // R5
    done_flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (done_q && !wr) |=> done_q);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int TRACK_TICKS = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic [N_TMR-1:0] tmr_ovf,
    input  logic             cnv_pin,
    input  logic [DIV_W-1:0] sar_div,
    input  logic             sar_done,
    input  logic             win_match,
    output logic             sar_tick,
    output logic             track_req,
    output logic             conv_req
);
    logic       en, lp_track, sw_go, pin_lvl, trig, busy, done_pulse;
    start_src_e src;

    adc_sar_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst(rst), .div(sar_div), .tick(sar_tick)
    );

    adc_ctl_regs u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .wdata(reg_wdata),
        .busy(busy), .done_pulse(done_pulse), .win_match(win_match),
        .rdata(reg_rdata), .en(en), .lp_track(lp_track), .src(src), .sw_go(sw_go)
    );

    adc_start_sel #(.SYNC_STAGES(SYNC_STAGES)) u_sel (
        .clk(clk), .rst(rst), .en(en), .src(src), .sw_go(sw_go),
        .tmr_ovf(tmr_ovf), .pin_async(cnv_pin), .pin_lvl(pin_lvl), .trig(trig)
    );

    adc_seq_fsm #(.TRACK_TICKS(TRACK_TICKS)) u_fsm (
        .clk(clk), .rst(rst), .en(en), .lp_track(lp_track),
        .pin_mode(src == SRC_PIN), .pin_lvl(pin_lvl), .trig(trig),
        .sar_tick(sar_tick), .sar_done(sar_done), .busy(busy),
        .done_pulse(done_pulse), .track_req(track_req), .conv_req(conv_req)
    );

    // R2
    off_no_requests_chk: assert property (@(posedge clk) disable iff (rst)
        (!reg_rdata[7] && !$past(reg_rdata[7])) |-> (!track_req && !conv_req));

endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [3:0] tmr_ovf = 4'h0;
    logic       cnv_pin = 1'b0;
    logic [7:0] sar_div = 8'd3;
    logic       sar_done = 1'b0;
    logic       win_match = 1'b0;
    logic       sar_tick, track_req, conv_req;

    int errors = 0;
    int checks = 0;

    typedef struct { string req; int ticks; } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    adc_seq_ctrl dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tmr_ovf(tmr_ovf), .cnv_pin(cnv_pin),
        .sar_div(sar_div), .sar_done(sar_done), .win_match(win_match),
        .sar_tick(sar_tick), .track_req(track_req), .conv_req(conv_req)
    );

    task automatic check(input logic ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic wr(input logic en, input logic tm, input logic df,
                      input logic bz, input logic wf, input logic [2:0] m);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_wdata = {en, tm, df, bz, wf, m};
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic pulse_tmr(input logic [3:0] v);
        @(negedge clk);
        tmr_ovf = v;
        @(negedge clk);
        tmr_ovf = 4'h0;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!reg_rdata[4]) break;
        end
    endtask

    // SAR core model: one-cycle done after five cycles of conv_req
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (sar_done) sar_done = 1'b0;
            else if (conv_req) begin
                cnt++;
                if (cnt >= 5) begin
                    sar_done = 1'b1;
                    cnt = 0;
                end
            end else cnt = 0;
        end
    end

    // Monitor: pops one expected item for each conversion start
    initial begin
        logic prev_conv = 1'b0;
        logic prev_track = 1'b0;
        int   run = 0;
        exp_t it;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (track_req && !prev_track) run = 0;
                if (track_req && sar_tick) run++;
                if (conv_req && !prev_conv) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R12 unexpected conversion start", 1, 0);
                    end else begin
                        it = exp_q.pop_front();
                        check(1'b1, it.req, 0, 0);
                        if (it.ticks >= 0)
                            check(run == it.ticks, {it.req, " track strobes"}, run, it.ticks);
                    end
                end
            end
            prev_conv  = conv_req;
            prev_track = track_req;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        summary();
    end

    initial begin
        int t;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset value
        check(reg_rdata == 8'h00, "R1 reset value", reg_rdata, 0);
        check(!track_req && !conv_req, "R2 outputs idle at reset", {track_req, conv_req}, 0);

        // R2 disabled: triggers ignored
        pulse_tmr(4'hF);
        wr(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000);
        idle_cycles(10);
        check(!reg_rdata[4] && !conv_req && !track_req, "R2 disabled ignores triggers", reg_rdata[4], 0);

        // R13 strobe period sar_div+1 = 4
        t = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sar_tick) t++;
        end
        check(t == 10, "R13 strobe count over 40 cycles", t, 10);

        // R1 layout and R6 continuous tracking
        wr(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000);
        check(reg_rdata == 8'h80, "R1 enable at bit 7", reg_rdata, 8'h80);
        check(track_req == 1'b1, "R6 tracks while idle", track_req, 1);

        // R4 busy 0 has no effect
        wr(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000);
        idle_cycles(10);
        check(!reg_rdata[4], "R4 busy write 0 no effect", reg_rdata[4], 0);

        // R4 R5 software start
        exp_q.push_back('{"R4 software start", -1});
        wr(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000);
        check(reg_rdata[4] == 1'b1, "R5 busy during conversion", reg_rdata[4], 1);
        check(track_req == 1'b0, "R6 no tracking while busy", track_req, 0);
        wait_idle();
        check(reg_rdata[5] == 1'b1, "R5 completion flag set", reg_rdata[5], 1);
        idle_cycles(8);
        check(reg_rdata[5] == 1'b1, "R5 completion flag sticky", reg_rdata[5], 1);
        wr(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000);
        check(reg_rdata[5] == 1'b0, "R5 completion flag cleared", reg_rdata[5], 0);

        // R3 timer sources: 001->0, 010->2, 011->1, 101->3
        for (int k = 0; k < 4; k++) begin
            logic [2:0] m;
            logic [3:0] sel;
            case (k)
                0: begin m = 3'b001; sel = 4'b0001; end
                1: begin m = 3'b010; sel = 4'b0100; end
                2: begin m = 3'b011; sel = 4'b0010; end
                default: begin m = 3'b101; sel = 4'b1000; end
            endcase
            wr(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, m);
            pulse_tmr(~sel);
            idle_cycles(10);
            exp_q.push_back('{"R3 timer source", -1});
            pulse_tmr(sel);
            wait_idle();
            check(reg_rdata[5] == 1'b1, "R3 timer source completes", reg_rdata[5], 1);
            wr(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, m);
        end

        // R3 reserved codes
        for (int m = 6; m < 8; m++) begin
            wr(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'(m));
            pulse_tmr(4'hF);
            wr(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'(m));
            idle_cycles(10);
            check(!reg_rdata[4] && !reg_rdata[5], "R3 reserved code starts nothing", reg_rdata[5:4], 0);
        end

        // R7 low-power timed tracking, R12 retrigger while busy
        wr(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'b001);
        idle_cycles(3);
        check(track_req == 1'b0, "R7 no tracking before trigger", track_req, 1'b0);
        exp_q.push_back('{"R7 timer low-power", 3});
        pulse_tmr(4'b0001);
        check(track_req == 1'b1, "R7 tracking after trigger", track_req, 1);
        pulse_tmr(4'b0001);
        wait_idle();
        idle_cycles(20);
        check(reg_rdata[5] == 1'b1, "R12 one conversion completed", reg_rdata[5], 1);
        wr(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000);
        exp_q.push_back('{"R7 software low-power", 3});
        wr(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 3'b000);
        wait_idle();
        wr(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'b100);

        // R8 pin rising edge, normal tracking
        exp_q.push_back('{"R8 pin edge start", -1});
        @(negedge clk);
        cnv_pin = 1'b1;
        idle_cycles(3);
        wait_idle();
        idle_cycles(15);
        cnv_pin = 1'b0;
        idle_cycles(5);

        // R8 pin low-power tracking
        wr(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'b100);
        idle_cycles(4);
        check(track_req == 1'b1, "R8 tracks while pin low", track_req, 1);
        exp_q.push_back('{"R8 pin low-power start", -1});
        cnv_pin = 1'b1;
        idle_cycles(4);
        check(track_req == 1'b0, "R8 stops tracking on pin high", track_req, 0);
        wait_idle();
        idle_cycles(5);
        check(track_req == 1'b0, "R8 no tracking while pin high", track_req, 0);
        cnv_pin = 1'b0;
        idle_cycles(4);

        // R10 abort
        wr(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000);
        exp_q.push_back('{"R10 start before abort", -1});
        wr(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000);
        idle_cycles(2);
        wr(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000);
        check(conv_req == 1'b0, "R10 conv_req drops", conv_req, 0);
        idle_cycles(2);
        check(reg_rdata[4] == 1'b0, "R10 busy cleared", reg_rdata[4], 0);
        idle_cycles(10);
        check(reg_rdata[5] == 1'b0, "R10 no completion flag", reg_rdata[5], 0);

        // R9 window flag
        @(negedge clk);
        win_match = 1'b1;
        @(negedge clk);
        win_match = 1'b0;
        check(reg_rdata[3] == 1'b1, "R9 window flag set", reg_rdata[3], 1);
        idle_cycles(6);
        check(reg_rdata[3] == 1'b1, "R9 window flag sticky", reg_rdata[3], 1);
        wr(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000);
        check(reg_rdata[3] == 1'b0, "R9 window flag cleared", reg_rdata[3], 0);

        // R11 set wins over clear
        @(negedge clk);
        win_match = 1'b1;
        reg_wr    = 1'b1;
        reg_wdata = 8'h00;
        @(negedge clk);
        win_match = 1'b0;
        reg_wr    = 1'b0;
        check(reg_rdata[3] == 1'b1, "R11 set beats clearing write", reg_rdata[3], 1);

        idle_cycles(5);
        check(exp_q.size() == 0, "R3 all expected conversions seen", exp_q.size(), 0);
        summary();
    end
endmodule